// File: doc/BRIEF.md
# Register Bank Save Controller

This block keeps track of a small stack of hardware context banks that hold a processor's working state when an interrupt is taken. An exception-entry strobe arrives with a type code, a vector number and the full context word. The block then does one of four things: it writes the context into the next free bank, it asks for the context to be pushed to the memory stack, it raises a bank-overflow exception, or it does nothing. A restore strobe pops the most recent bank and returns its context and vector number.

Only ordinary maskable interrupts use the banks, and only while bank use is enabled. Once every bank holds a saved context, a control input decides what happens next: a stack-save request or an overflow exception. Every decision is registered. Each outcome appears as a one-cycle pulse in the cycle after the strobe, and the bank pointer changes at the same clock edge.

Top module: `regbank_save_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the bank pointer reads 0 and every outcome pulse (bank write, stack save, overflow, underflow, collision, restore valid) is low.
- R2: An exception of kind 0 (maskable interrupt) with bank enable high, and with the pointer below 15, pulses the bank write one cycle later. The bank index equals the old pointer, the pointer goes up by one, and the context and vector number are stored in that bank.
- R3: Exception kinds 1 (NMI), 2 (user break), 3 (address error), 4 (bus error), 5 (instruction-initiated) and 6–7 (reserved) never write a bank, never request a stack save, never raise an overflow, and leave the pointer unchanged.
- R4: With bank enable low, a kind-0 exception writes no bank, makes no stack request, raises no overflow, and leaves the pointer unchanged, whatever the pointer value.
- R5: A kind-0 exception with bank enable high, the pointer at 15 and overflow-enable low pulses the stack-save request and keeps the pointer at 15.
- R6: The same case with overflow-enable high pulses the overflow exception and makes no stack request.
- R7: A restore strobe with the pointer above 0 lowers the pointer by one. One cycle later it pulses restore valid, with the context and vector number of bank (old pointer − 1), so banks come back in last-in first-out order.
- R8: A restore strobe with the pointer at 0 pulses the underflow flag and leaves the pointer at 0.
- R9: An exception strobe and a restore strobe in the same cycle pulse the collision flag, produce no other outcome, and leave the pointer unchanged.
- R10: At most one outcome pulse is high in any cycle, every pulse lasts one cycle, and the pointer never goes above 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Exception-entry strobe |
| exc_kind_i | input | 3 | Exception type code (0 = maskable interrupt) |
| exc_vec_i | input | VEC_W | Vector number of the exception |
| bank_en_i | input | 1 | Register bank use enabled |
| ovf_en_i | input | 1 | Full banks raise overflow (1) or fall back to stack (0) |
| restore_i | input | 1 | Restore (pop) strobe |
| ctx_i | input | NUM_REGS*DATA_W | Context to be saved |
| bank_we_o | output | 1 | Bank write pulse |
| bank_idx_o | output | PTR_W | Bank written by the current pulse |
| stack_save_o | output | 1 | Stack-save request pulse |
| ovf_exc_o | output | 1 | Bank-overflow exception pulse |
| underflow_o | output | 1 | Restore with no saved bank |
| collide_o | output | 1 | Save and restore strobed together |
| bank_ptr_o | output | PTR_W | Number of banks in use |
| restore_vld_o | output | 1 | Restored data valid pulse |
| restore_vec_o | output | VEC_W | Vector number of the restored bank |
| restore_ctx_o | output | NUM_REGS*DATA_W | Context of the restored bank |

## Verification
The hardest states to reach are the ones at a full bank stack: the stack fallback, the overflow exception, and collisions or filtered kinds while full. They need fifteen accepted saves first. The bench builds up that depth with a run of kind-0 exceptions, each carrying its own vector number. At full depth it tries both overflow-enable settings, a disabled bank, an NMI and a collision. It then unwinds all fifteen banks and checks the returned vectors and contexts in reverse order.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    EXC_IRQ  = 3'd0,
    EXC_NMI  = 3'd1,
    EXC_UBRK = 3'd2,
    EXC_ADDR = 3'd3,
    EXC_BUS  = 3'd4,
    EXC_INSN = 3'd5,
    EXC_RSV6 = 3'd6,
    EXC_RSV7 = 3'd7
  } exc_kind_e;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_BANK  = 3'd1,
    ACT_STACK = 3'd2,
    ACT_OVF   = 3'd3,
    ACT_POP   = 3'd4,
    ACT_UNDER = 3'd5,
    ACT_COLL  = 3'd6
  } act_e;

  // Only ordinary maskable interrupts may use the context banks.
  function automatic logic kind_uses_bank(exc_kind_e k);
    return k == EXC_IRQ;
  endfunction

endpackage

// File: rtl/regbank_decide.sv
module regbank_decide
  import regbank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = 4
) (
  input  logic             exc_valid,
  input  exc_kind_e        exc_kind,
  input  logic             bank_en,
  input  logic             ovf_en,
  input  logic             restore,
  input  logic [PTR_W-1:0] ptr,
  output act_e             act
);

  localparam logic [PTR_W-1:0] FULL = PTR_W'(NUM_BANKS);

  always_comb begin
    act = ACT_NONE;
    if (exc_valid && restore) begin
      act = ACT_COLL;
    end else if (restore) begin
      act = (ptr == '0) ? ACT_UNDER : ACT_POP;
    end else if (exc_valid && bank_en && kind_uses_bank(exc_kind)) begin
      if (ptr < FULL)  act = ACT_BANK;
      else if (ovf_en) act = ACT_OVF;
      else             act = ACT_STACK;
    end
  end

endmodule

// File: rtl/regbank_ptr.sv
module regbank_ptr
  import regbank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] FULL = PTR_W'(NUM_BANKS);

  // Saturating step of the bank pointer for a given outcome.
  function automatic logic [PTR_W-1:0] ptr_after(act_e a, logic [PTR_W-1:0] p);
    case (a)
      ACT_BANK: return (p == FULL) ? p : p + PTR_W'(1);
      ACT_POP:  return (p == '0)   ? p : p - PTR_W'(1);
      default:  return p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_after(act, ptr);
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int NUM_BANKS = 15,
  parameter int CTX_W     = 608,
  parameter int VEC_W     = 8,
  parameter int PTR_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [CTX_W-1:0] rd_ctx,
  output logic [VEC_W-1:0] rd_vec
);

  logic [CTX_W-1:0] ctx_mem [NUM_BANKS];
  logic [VEC_W-1:0] vec_mem [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wire sel = wr_en && (wr_idx == PTR_W'(b));
    always_ff @(posedge clk) begin
      if (sel) begin
        ctx_mem[b] <= wr_ctx;
        vec_mem[b] <= wr_vec;
      end
    end
  end

  wire rd_ok = rd_en && (rd_idx < PTR_W'(NUM_BANKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_ctx <= '0;
      rd_vec <= '0;
    end else begin
      rd_vld <= rd_ok;
      if (rd_ok) begin
        rd_ctx <= ctx_mem[rd_idx];
        rd_vec <= vec_mem[rd_idx];
      end
    end
  end

endmodule

// File: rtl/regbank_save_ctrl.sv
module regbank_save_ctrl
  import regbank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int NUM_REGS  = 19,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  exc_valid_i,
  input  logic [2:0]                            exc_kind_i,
  input  logic [VEC_W-1:0]                      exc_vec_i,
  input  logic                                  bank_en_i,
  input  logic                                  ovf_en_i,
  input  logic                                  restore_i,
  input  logic [NUM_REGS*DATA_W-1:0]            ctx_i,
  output logic                                  bank_we_o,
  output logic [$clog2(NUM_BANKS+1)-1:0]        bank_idx_o,
  output logic                                  stack_save_o,
  output logic                                  ovf_exc_o,
  output logic                                  underflow_o,
  output logic                                  collide_o,
  output logic [$clog2(NUM_BANKS+1)-1:0]        bank_ptr_o,
  output logic                                  restore_vld_o,
  output logic [VEC_W-1:0]                      restore_vec_o,
  output logic [NUM_REGS*DATA_W-1:0]            restore_ctx_o
);

  localparam int PTR_W = $clog2(NUM_BANKS + 1);
  localparam int CTX_W = NUM_REGS * DATA_W;

  act_e             act;
  logic [PTR_W-1:0] ptr;

  // Named per-cycle events, decoded from the chosen outcome.
  wire ev_bank  = (act == ACT_BANK);
  wire ev_stack = (act == ACT_STACK);
  wire ev_ovf   = (act == ACT_OVF);
  wire ev_pop   = (act == ACT_POP);
  wire ev_under = (act == ACT_UNDER);
  wire ev_coll  = (act == ACT_COLL);

  regbank_decide #(.NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) decide_i (
    .exc_valid (exc_valid_i),
    .exc_kind  (exc_kind_e'(exc_kind_i)),
    .bank_en   (bank_en_i),
    .ovf_en    (ovf_en_i),
    .restore   (restore_i),
    .ptr       (ptr),
    .act       (act)
  );

  regbank_ptr #(.NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) ptr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .ptr   (ptr)
  );

  regbank_store #(
    .NUM_BANKS (NUM_BANKS),
    .CTX_W     (CTX_W),
    .VEC_W     (VEC_W),
    .PTR_W     (PTR_W)
  ) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ev_bank),
    .wr_idx (ptr),
    .wr_ctx (ctx_i),
    .wr_vec (exc_vec_i),
    .rd_en  (ev_pop),
    .rd_idx (ptr - PTR_W'(1)),
    .rd_vld (restore_vld_o),
    .rd_ctx (restore_ctx_o),
    .rd_vec (restore_vec_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_we_o    <= 1'b0;
      bank_idx_o   <= '0;
      stack_save_o <= 1'b0;
      ovf_exc_o    <= 1'b0;
      underflow_o  <= 1'b0;
      collide_o    <= 1'b0;
    end else begin
      bank_we_o    <= ev_bank;
      if (ev_bank) bank_idx_o <= ptr;
      stack_save_o <= ev_stack;
      ovf_exc_o    <= ev_ovf;
      underflow_o  <= ev_under;
      collide_o    <= ev_coll;
    end
  end

  assign bank_ptr_o = ptr;

endmodule

// File: rtl/regbank_save_ctrl_chk.sv
module regbank_save_ctrl_chk #(
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_valid,
  input logic [2:0]       exc_kind,
  input logic             bank_en,
  input logic             ovf_en,
  input logic             restore,
  input logic             bank_we,
  input logic [PTR_W-1:0] bank_idx,
  input logic             stack_save,
  input logic             ovf_exc,
  input logic             underflow,
  input logic             collide,
  input logic             restore_vld,
  input logic [PTR_W-1:0] bank_ptr
);

  localparam logic [PTR_W-1:0] FULL = PTR_W'(NUM_BANKS);

  p_save_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (bank_ptr == $past(bank_ptr) + PTR_W'(1)) && (bank_idx == $past(bank_ptr)));

  p_kind_filtered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !restore && exc_kind != 3'd0)
      |=> !bank_we && !stack_save && !ovf_exc && $stable(bank_ptr));

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !restore && !bank_en)
      |=> !bank_we && !stack_save && !ovf_exc && $stable(bank_ptr));

  p_stack_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stack_save |-> ($past(bank_ptr) == FULL) && (bank_ptr == FULL) && !$past(ovf_en));

  p_ovf_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_exc |-> ($past(bank_ptr) == FULL) && (bank_ptr == FULL) && $past(ovf_en));

  p_pop_steps_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_vld |-> (bank_ptr == $past(bank_ptr) - PTR_W'(1)));

  p_underflow_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (bank_ptr == '0) && ($past(bank_ptr) == '0));

  p_collision_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && restore) |=> collide && $stable(bank_ptr));

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_we, stack_save, ovf_exc, underflow, collide, restore_vld}));

  p_ptr_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ptr <= FULL);

endmodule

bind regbank_save_ctrl regbank_save_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .PTR_W     ($clog2(NUM_BANKS + 1))
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_valid   (exc_valid_i),
  .exc_kind    (exc_kind_i),
  .bank_en     (bank_en_i),
  .ovf_en      (ovf_en_i),
  .restore     (restore_i),
  .bank_we     (bank_we_o),
  .bank_idx    (bank_idx_o),
  .stack_save  (stack_save_o),
  .ovf_exc     (ovf_exc_o),
  .underflow   (underflow_o),
  .collide     (collide_o),
  .restore_vld (restore_vld_o),
  .bank_ptr    (bank_ptr_o)
);

// File: tb/regbank_save_ctrl_tb_top.sv
`timescale 1ns/1ps
module regbank_save_ctrl_tb_top;

  localparam int NB    = 15;
  localparam int NR    = 19;
  localparam int DW    = 32;
  localparam int VW    = 8;
  localparam int CW    = NR * DW;
  localparam int PW    = 4;
  localparam int NROWS = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exc_valid = 1'b0;
  logic [2:0]    exc_kind = 3'd0;
  logic [VW-1:0] exc_vec = '0;
  logic          bank_en = 1'b0;
  logic          ovf_en = 1'b0;
  logic          restore = 1'b0;
  logic [CW-1:0] ctx = '0;
  logic          bank_we, stack_save, ovf_exc, underflow, collide, restore_vld;
  logic [PW-1:0] bank_idx, bank_ptr;
  logic [VW-1:0] restore_vec;
  logic [CW-1:0] restore_ctx;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  regbank_save_ctrl #(.NUM_BANKS(NB), .NUM_REGS(NR), .DATA_W(DW), .VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid), .exc_kind_i(exc_kind),
    .exc_vec_i(exc_vec), .bank_en_i(bank_en), .ovf_en_i(ovf_en), .restore_i(restore),
    .ctx_i(ctx), .bank_we_o(bank_we), .bank_idx_o(bank_idx), .stack_save_o(stack_save),
    .ovf_exc_o(ovf_exc), .underflow_o(underflow), .collide_o(collide),
    .bank_ptr_o(bank_ptr), .restore_vld_o(restore_vld), .restore_vec_o(restore_vec),
    .restore_ctx_o(restore_ctx)
  );

  typedef struct packed {
    logic          exc;
    logic [2:0]    kind;
    logic [VW-1:0] vec;
    logic          ben;
    logic          oen;
    logic          rst;
    logic          we;
    logic [PW-1:0] idx;
    logic          stk;
    logic          ovf;
    logic          unf;
    logic          col;
    logic          rvld;
    logic [VW-1:0] rvec;
    logic [PW-1:0] ptr;
  } row_t;

  // stimulus: exc kind vec ben oen rst | expected: we idx stk ovf unf col rvld rvec ptr
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1,  1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd0}, // R8
    '{1'b1, 3'd0, 8'h40, 1'b1, 1'b0, 1'b0,  1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R2
    '{1'b1, 3'd1, 8'h50, 1'b1, 1'b0, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R3
    '{1'b1, 3'd3, 8'h51, 1'b1, 1'b0, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R3
    '{1'b1, 3'd0, 8'h52, 1'b0, 1'b0, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R4
    '{1'b1, 3'd0, 8'h41, 1'b1, 1'b0, 1'b0,  1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2}, // R2
    '{1'b1, 3'd0, 8'h53, 1'b1, 1'b0, 1'b1,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'd2}, // R9
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h41, 4'd1}, // R7
    '{1'b1, 3'd2, 8'h54, 1'b1, 1'b0, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R3
    '{1'b1, 3'd4, 8'h55, 1'b1, 1'b0, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R3
    '{1'b1, 3'd5, 8'h56, 1'b1, 1'b1, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, // R3
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 4'd0}, // R7
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd0}  // R10
  };

  function automatic string row_req(int r);
    case (r)
      0:        return "R8";
      1, 5:     return "R2";
      4:        return "R4";
      6:        return "R9";
      7, 11:    return "R7";
      12:       return "R10";
      default:  return "R3";
    endcase
  endfunction

  // Context pattern tied to the vector number, so each bank holds distinct data.
  function automatic logic [CW-1:0] make_ctx(logic [VW-1:0] v);
    logic [CW-1:0] c;
    for (int r = 0; r < NR; r++) c[r*DW +: DW] = {v, 8'(r), ~v, 8'h5A};
    return c;
  endfunction

  task automatic check_eq(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one strobe cycle from a falling edge; return at the next falling edge,
  // where the registered outcome of that strobe is visible.
  task automatic step(logic e, logic [2:0] k, logic [VW-1:0] v, logic be, logic oe, logic rs);
    exc_valid = e; exc_kind = k; exc_vec = v; bank_en = be; ovf_en = oe; restore = rs;
    ctx = make_ctx(v);
    @(negedge clk);
    exc_valid = 1'b0; restore = 1'b0;
  endtask

  task automatic check_quiet(string req);
    check_eq(req, "bank_we", bank_we, 0);
    check_eq(req, "stack_save", stack_save, 0);
    check_eq(req, "ovf_exc", ovf_exc, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_eq("R1", "ptr in reset", bank_ptr, 0);
    check_eq("R1", "pulses in reset",
             {bank_we, stack_save, ovf_exc, underflow, collide, restore_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "ptr after reset", bank_ptr, 0);

    // Table walk
    for (int r = 0; r < NROWS; r++) begin
      step(TBL[r].exc, TBL[r].kind, TBL[r].vec, TBL[r].ben, TBL[r].oen, TBL[r].rst);
      check_eq(row_req(r), $sformatf("row %0d bank_we", r), bank_we, TBL[r].we);
      if (TBL[r].we) check_eq(row_req(r), $sformatf("row %0d bank_idx", r), bank_idx, TBL[r].idx);
      check_eq(row_req(r), $sformatf("row %0d stack_save", r), stack_save, TBL[r].stk);
      check_eq(row_req(r), $sformatf("row %0d ovf_exc", r), ovf_exc, TBL[r].ovf);
      check_eq(row_req(r), $sformatf("row %0d underflow", r), underflow, TBL[r].unf);
      check_eq(row_req(r), $sformatf("row %0d collide", r), collide, TBL[r].col);
      check_eq(row_req(r), $sformatf("row %0d restore_vld", r), restore_vld, TBL[r].rvld);
      if (TBL[r].rvld) check_eq(row_req(r), $sformatf("row %0d restore_vec", r), restore_vec, TBL[r].rvec);
      check_eq(row_req(r), $sformatf("row %0d ptr", r), bank_ptr, TBL[r].ptr);
    end

    // R2: fill every bank
    for (int i = 0; i < NB; i++) begin
      step(1'b1, 3'd0, 8'(8'h80 + i), 1'b1, 1'b0, 1'b0);
      check_eq("R2", $sformatf("fill %0d bank_we", i), bank_we, 1);
      check_eq("R2", $sformatf("fill %0d bank_idx", i), bank_idx, i);
      check_eq("R2", $sformatf("fill %0d ptr", i), bank_ptr, i + 1);
    end

    // R5: full, overflow disabled -> stack fallback
    step(1'b1, 3'd0, 8'hC0, 1'b1, 1'b0, 1'b0);
    check_eq("R5", "stack_save", stack_save, 1);
    check_eq("R5", "bank_we", bank_we, 0);
    check_eq("R5", "ovf_exc", ovf_exc, 0);
    check_eq("R5", "ptr", bank_ptr, NB);
    @(negedge clk);
    check_eq("R10", "stack pulse one cycle", stack_save, 0);

    // R6: full, overflow enabled -> overflow exception
    step(1'b1, 3'd0, 8'hC1, 1'b1, 1'b1, 1'b0);
    check_eq("R6", "ovf_exc", ovf_exc, 1);
    check_eq("R6", "stack_save", stack_save, 0);
    check_eq("R6", "ptr", bank_ptr, NB);

    // R4: full but bank use disabled -> nothing
    step(1'b1, 3'd0, 8'hC2, 1'b0, 1'b0, 1'b0);
    check_quiet("R4");
    check_eq("R4", "ptr full", bank_ptr, NB);

    // R3: NMI at full depth -> nothing
    step(1'b1, 3'd1, 8'hC3, 1'b1, 1'b0, 1'b0);
    check_quiet("R3");
    check_eq("R3", "ptr full", bank_ptr, NB);

    // R9: collision at full depth
    step(1'b1, 3'd0, 8'hC4, 1'b1, 1'b1, 1'b1);
    check_eq("R9", "collide", collide, 1);
    check_eq("R9", "ovf_exc", ovf_exc, 0);
    check_eq("R9", "restore_vld", restore_vld, 0);
    check_eq("R9", "ptr", bank_ptr, NB);

    // R7: unwind all banks in reverse order
    for (int i = NB - 1; i >= 0; i--) begin
      step(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1);
      check_eq("R7", $sformatf("pop %0d restore_vld", i), restore_vld, 1);
      check_eq("R7", $sformatf("pop %0d restore_vec", i), restore_vec, 8'h80 + i);
      check_eq("R7", $sformatf("pop %0d ctx match", i),
               longint'(restore_ctx == make_ctx(8'(8'h80 + i))), 1);
      check_eq("R7", $sformatf("pop %0d ptr", i), bank_ptr, i);
    end

    // R8: restore on empty
    step(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1);
    check_eq("R8", "underflow", underflow, 1);
    check_eq("R8", "restore_vld", restore_vld, 0);
    check_eq("R8", "ptr", bank_ptr, 0);

    // R1: reset in the middle of a run
    for (int i = 0; i < 3; i++) step(1'b1, 3'd0, 8'(8'h20 + i), 1'b1, 1'b0, 1'b0);
    check_eq("R1", "ptr before reset", bank_ptr, 3);
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1", "ptr after mid reset", bank_ptr, 0);
    check_eq("R1", "pulses after mid reset",
             {bank_we, stack_save, ovf_exc, underflow, collide, restore_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule